// File: doc/BRIEF.md
# Addressed Serial Control Word Receiver

This block takes control frames from a three-wire bus: a bus clock, a data line and an enable line. All three wires are asynchronous to the system clock. Each wire passes through a two-flop synchronizer, and the block finds bus clock edges in the system clock domain. While enable is low, each rising bus clock edge shifts one bit into an 8-bit address register. Bits go in least significant first, and only the last eight bits before enable rises count. When enable rises, the block compares that address with its own device address. While enable is high, each rising bus clock edge shifts one bit into a 44-bit data register. Here too bits go in least significant first, and only the last 44 bits are kept. A host can therefore pad a frame to a byte multiple by putting don't-care bits ahead of the first data bit.

The word is committed when enable falls, and only if two conditions hold: the address matched, and at least 44 data bits arrived. The block then drives the word on its output and raises a strobe for one system clock cycle. The output is a plain push strobe with no ready input. The serial host cannot be stalled, so the downstream logic must take the word in the cycle the strobe is high. The word output holds its value until the next committed frame.

Top module: `serial_ctrl_rx`

## Requirements
- R1: After reset, `word_valid` is 0 and `word_data` is all zeros, and no strobe appears until a complete frame has been received.
- R2: The device address is 8'h81. A frame is accepted only if the eight address bits, sent least significant bit first, equal this value.
- R3: Bits clocked while enable is low go only to the address register. When enable rises, only the last eight such bits form the address, so earlier bits sent with enable low have no effect.
- R4: A frame is committed only on the falling edge of enable. `word_valid` is then high for exactly one system clock cycle, within a few cycles of the fall.
- R5: Data is sampled on the rising edge of the bus clock. In a 44-bit frame, the first data bit sent appears at `word_data[0]` and the last at `word_data[43]`.
- R6: If more than 44 data bits arrive (for example 48 bits, with 4 don't-care bits first), only the final 44 are kept. The bit sent 44th from the end lands at `word_data[0]`.
- R7: If enable falls after fewer than 44 data bits, the frame is discarded: there is no strobe and `word_data` keeps its previous value.
- R8: A frame whose address is not 8'h81 is discarded: there is no strobe and `word_data` keeps its previous value.
- R9: `word_data` changes only in a cycle where `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk | input | 1 | Serial bus clock (asynchronous) |
| bus_dat | input | 1 | Serial bus data (asynchronous) |
| bus_en | input | 1 | Serial bus enable: low for the address, high for the data (asynchronous) |
| word_data | output | 44 | Last committed control word |
| word_valid | output | 1 | One-cycle strobe when a new word is committed |

## Verification
The bench sends several kinds of frame:
- Exact 44-bit frames with two different patterns. These tell a correct bit order from a reversed or shifted one.
- A 48-bit padded frame. This separates keeping the trailing bits from keeping the leading ones.
- A frame with junk bits before the address. This shows that only the last eight bits before enable rises count as the address.
- Frames with a wrong address and with 43 data bits. Both must produce no strobe and leave the held word unchanged, which shows that each discard rule works on its own.

For every frame the bench counts the cycles in which the strobe is high, to confirm a single-cycle commit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  parameter int unsigned SRX_ADDR_W = 8;
  parameter int unsigned SRX_WORD_W = 44;
  parameter logic [7:0]  SRX_DEV_ADDR = 8'h81;
  parameter int unsigned SRX_SYNC_STAGES = 2;
endpackage

// File: rtl/srx_pin_sync.sv
// Synchronizes a group of asynchronous pins and detects their edges.
module srx_pin_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[DEPTH-2:0], pin[i]};
    end
    assign level[i] = chain[STAGES-1];
    assign rise[i]  = chain[STAGES-1] & ~chain[STAGES];
    assign fall[i]  = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/srx_frame.sv
// Collects the address and data bits and commits the word when enable falls.
module srx_frame #(
  parameter int unsigned    ADDR_W   = 8,
  parameter int unsigned    WORD_W   = 44,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_val,
  input  logic              sclk_rise,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic              en_fall,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              addr_ok,
  output logic              cnt_full
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [ADDR_W-1:0] addr_sr;
  logic [WORD_W-1:0] data_sr;
  logic [CNT_W-1:0]  bit_cnt;

  assign cnt_full = (bit_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_sr    <= '0;
      data_sr    <= '0;
      bit_cnt    <= '0;
      addr_ok    <= 1'b0;
      word_data  <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (en_rise) begin
        addr_ok <= (addr_sr == DEV_ADDR);
        bit_cnt <= '0;
      end else if (en_fall) begin
        if (addr_ok && cnt_full) begin
          word_data  <= data_sr;
          word_valid <= 1'b1;
        end
        addr_ok <= 1'b0;
        addr_sr <= '0;
      end else if (sclk_rise) begin
        if (en_lvl) begin
          data_sr <= {bit_val, data_sr[WORD_W-1:1]};
          if (!cnt_full) bit_cnt <= bit_cnt + 1'b1;
        end else begin
          addr_sr <= {bit_val, addr_sr[ADDR_W-1:1]};
        end
      end
    end
  end
endmodule

// File: rtl/serial_ctrl_rx.sv
module serial_ctrl_rx
  import srx_pkg::*;
#(
  parameter int unsigned       ADDR_W   = SRX_ADDR_W,
  parameter int unsigned       WORD_W   = SRX_WORD_W,
  parameter logic [ADDR_W-1:0] DEV_ADDR = SRX_DEV_ADDR,
  parameter int unsigned       STAGES   = SRX_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              bus_dat,
  input  logic              bus_en,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] lvl, rise, fall;
  logic en_lvl, addr_ok, cnt_full;

  srx_pin_sync #(.N(NPIN), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({bus_en, bus_dat, bus_clk}),
    .level(lvl),
    .rise (rise),
    .fall (fall)
  );

  assign en_lvl = lvl[2];

  srx_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_val   (lvl[1]),
    .sclk_rise (rise[0]),
    .en_lvl    (en_lvl),
    .en_rise   (rise[2]),
    .en_fall   (fall[2]),
    .word_data (word_data),
    .word_valid(word_valid),
    .addr_ok   (addr_ok),
    .cnt_full  (cnt_full)
  );

  logic unused_edges;
  assign unused_edges = ^{fall[1:0], rise[1]};
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int unsigned WORD_W = 44
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_data,
  input logic              word_valid,
  input logic              en_lvl,
  input logic              addr_ok,
  input logic              cnt_full
);
  // R4: the strobe lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R4: a commit only happens with enable low
  a_r4_en_low: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !en_lvl);
  // R9: the held word changes only with the strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));
  // R7: a commit needs a full count of data bits
  a_r7_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(cnt_full));
  // R8: a commit needs a matching address
  a_r8_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(addr_ok));
endmodule

bind serial_ctrl_rx srx_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_data (word_data),
  .word_valid(word_valid),
  .en_lvl    (en_lvl),
  .addr_ok   (addr_ok),
  .cnt_full  (cnt_full)
);

// File: tb/sim_serial_ctrl_rx.sv
`timescale 1ns/1ps
module sim_serial_ctrl_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, bus_dat = 1'b0, bus_en = 1'b0;
  logic [43:0] word_data;
  logic word_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [43:0] held = '0;
  int pulses;
  logic [43:0] got;

  always #10 clk = ~clk;

  serial_ctrl_rx u0 (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .bus_en(bus_en), .word_data(word_data), .word_valid(word_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic bus_bit(input logic b);
    bus_dat = b;
    wait_clk(4);
    bus_clk = 1'b1;
    wait_clk(4);
    bus_clk = 1'b0;
  endtask

  // Sends pre junk ones, the address (LSB first), n data bits d[0] first.
  task automatic send_frame(input logic [7:0] a, input int pre,
                            input logic [63:0] d, input int n);
    for (int i = 0; i < pre; i++) bus_bit(1'b1);
    for (int i = 0; i < 8; i++) bus_bit(a[i]);
    wait_clk(4);
    bus_en = 1'b1;
    wait_clk(4);
    for (int i = 0; i < n; i++) bus_bit(d[i]);
    wait_clk(4);
    bus_en = 1'b0;
    pulses = 0;
    got = word_data;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (word_valid) begin
        pulses++;
        got = word_data;
      end
    end
  endtask

  task automatic expect_commit(input string req, input logic [43:0] exp);
    check(pulses == 1, {req, " strobe count"}, pulses, 1);
    check(got == exp, {req, " word"}, got, exp);
    held = exp;
  endtask

  task automatic expect_discard(input string req);
    check(pulses == 0, {req, " no strobe"}, pulses, 0);
    @(negedge clk);
    check(word_data == held, {req, " word kept"}, word_data, held);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(word_valid == 1'b0, "R1 valid", word_valid, 0);
    check(word_data == '0, "R1 data", word_data, 0);
  endtask

  task automatic t_basic;
    logic [63:0] d = 64'h0000_0A5C_3F19_E2D7;
    send_frame(8'h81, 0, d, 44);
    expect_commit("R2 R4 R5 basic", d[43:0]);
    d = 64'h0000_0800_0000_0001;
    send_frame(8'h81, 0, d, 44);
    expect_commit("R5 ends", d[43:0]);
  endtask

  task automatic t_padded;
    logic [63:0] d = 64'h0000_B123_4567_89AF;
    send_frame(8'h81, 0, d, 48);
    expect_commit("R6 padded", d[47:4]);
  endtask

  task automatic t_prefix;
    logic [63:0] d = 64'h0000_0333_CCCC_5555;
    send_frame(8'h81, 5, d, 44);
    expect_commit("R3 prefix", d[43:0]);
  endtask

  task automatic t_mismatch;
    send_frame(8'h80, 0, 64'h0000_0FFF_FFFF_FFFF, 44);
    expect_discard("R8 mismatch");
    send_frame(8'h18, 0, 64'h0000_0123_0000_0000, 44);
    expect_discard("R8 reversed");
  endtask

  task automatic t_short;
    send_frame(8'h81, 0, 64'h0000_0777_7777_7777, 43);
    expect_discard("R7 short");
    check(word_valid == 1'b0, "R9 idle", word_valid, 0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_short();
    t_basic();
    t_padded();
    t_prefix();
    t_mismatch();
    t_short();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule